// File: doc/BRIEF.md
# Host Bridge Memory-Attribute Register Block

This block is the slice of a host bridge's configuration space that controls how the legacy low-memory windows are routed. It stores seven shadow-attribute bytes and one management-RAM control byte. It also serves a read-only byte that reports the installed memory size. Software reaches these bytes through 32-bit configuration writes with per-byte lane enables, so each access can touch one, two or four bytes at any byte address. Reads are combinational: the dword at the presented address comes back with every byte this block owns filled in and every other byte read as zero.

From the stored bytes the block drives registered enables for the memory routing fabric:
- a read enable and a write enable for each shadow region (one BIOS region and the expansion regions);
- an enable that routes the non-management view of the 128 KiB window at 0xA0000 to the bus side;
- an enable that exposes that window as RAM to management-mode accesses.

These enables are loaded only on a clock edge where a write lands on an attribute byte or on the control byte. Between such writes they hold their values.

Top module: `hb_memattr_regs`

## Requirements
- R1: After reset, every shadow enable is 0, the control byte at offset 0x72 reads 0x02, all attribute bytes read 0, the bus-side window enable is 1 and the management enable is 0.
- R2: A write stores byte lane k of `cfg_wdata` (bits 8k+7..8k) at byte address 4*`cfg_dw_addr`+k only when `cfg_be[k]` is set. All eight bits of attribute bytes 0x59..0x5F and of control byte 0x72 are writable, and they read back in the same lane.
- R3: Region 0 (the BIOS window) takes its read enable from bit 4 and its write enable from bit 5 of byte 0x59.
- R4: Region i >= 1 is controlled by byte 0x59 + ceil(i/2). An odd i uses bit 0 (read) and bit 1 (write) of that byte, and an even i uses bit 4 (read) and bit 5 (write).
- R5: The bus-side window enable equals the inverse of bit 6 of byte 0x72.
- R6: The management-mode window enable equals bit 3 of byte 0x72.
- R7: All enables change on the clock edge that accepts a write touching 0x59..0x5F or 0x72, and not before that edge. Any other cycle leaves them unchanged, including a write whose enabled lanes all miss those bytes.
- R8: Byte 0x57 reads floor(`mem_size_mb`/8), saturated at 255. Writes to byte 0x57 have no effect.
- R9: Writes to any other offset are ignored, and such offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dw_addr | input | 6 | Dword address (byte address bits 7..2) |
| cfg_be | input | 4 | Byte-lane enables for the write |
| cfg_wdata | input | 32 | Write data, lane k in bits 8k+7..8k |
| cfg_rdata | output | 32 | Combinational read data of the addressed dword |
| mem_size_mb | input | 16 | Installed memory size in MiB |
| shadow_rd_en | output | 13 | Per-region read enable |
| shadow_wr_en | output | 13 | Per-region write enable |
| lowwin_pci_en | output | 1 | Non-management view of 0xA0000 window routed to bus side |
| lowwin_smm_en | output | 1 | Management-mode view of window mapped to RAM |

## Verification
The bench builds the block with its default parameters: 13 regions over seven attribute bytes, the control byte at 0x72 and a 16-bit size input. With these values the last attribute byte is shared by regions 11 and 12, and the size saturation point of 2048 MiB lies inside the input range. Random lane enables over the dwords 0x50 to 0x73 mix writes that straddle the edges of the attribute range with writes that miss it completely. These writes test both the update rule and the rule that writes outside the owned bytes are ignored.

// File: rtl/hb_memattr_regs.sv
module hb_memattr_regs #(
  parameter int CFG_AW      = 8,
  parameter int ATTR_BASE   = 'h59,
  parameter int ATTR_BYTES  = 7,
  parameter int NUM_REGIONS = 13,
  parameter int SMC_OFFSET  = 'h72,
  parameter int SMC_RESET   = 'h02,
  parameter int OPEN_BIT    = 6,
  parameter int GEN_BIT     = 3,
  parameter int SIZE_OFFSET = 'h57,
  parameter int MB_W        = 16,
  parameter int SIZE_SHIFT  = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [CFG_AW-3:0]      cfg_dw_addr,
  input  logic [3:0]             cfg_be,
  input  logic [31:0]            cfg_wdata,
  output logic [31:0]            cfg_rdata,
  input  logic [MB_W-1:0]        mem_size_mb,
  output logic [NUM_REGIONS-1:0] shadow_rd_en,
  output logic [NUM_REGIONS-1:0] shadow_wr_en,
  output logic                   lowwin_pci_en,
  output logic                   lowwin_smm_en
);
  localparam int DW = CFG_AW - 2;
  localparam logic [7:0] SMC_INIT = 8'(SMC_RESET);
  localparam int A0_LANE = ATTR_BASE % 4;
  localparam logic [DW-1:0] A0_DW = DW'(ATTR_BASE / 4);
  localparam int SMC_LANE = SMC_OFFSET % 4;
  localparam logic [DW-1:0] SMC_DW = DW'(SMC_OFFSET / 4);

  logic [7:0] attr_q [ATTR_BYTES];
  logic [7:0] attr_d [ATTR_BYTES];
  logic [7:0] smc_q, smc_d;
  logic       touch;
  logic [CFG_AW-1:0] lane_addr [4];
  logic [NUM_REGIONS-1:0] rd_nx, wr_nx;
  logic [MB_W-1:0] size_units;
  logic [7:0] size_code;

  for (genvar b = 0; b < 4; b++) begin : g_lane
    assign lane_addr[b] = {cfg_dw_addr, 2'(b)};
  end

  assign size_units = mem_size_mb >> SIZE_SHIFT;
  assign size_code  = (size_units > MB_W'(255)) ? 8'hFF : size_units[7:0];

  always_comb begin
    attr_d = attr_q;
    smc_d  = smc_q;
    touch  = 1'b0;
    for (int b = 0; b < 4; b++) begin
      if (cfg_we && cfg_be[b]) begin
        for (int j = 0; j < ATTR_BYTES; j++) begin
          if (lane_addr[b] == CFG_AW'(ATTR_BASE + j)) begin
            attr_d[j] = cfg_wdata[8*b +: 8];
            touch     = 1'b1;
          end
        end
        if (lane_addr[b] == CFG_AW'(SMC_OFFSET)) begin
          smc_d = cfg_wdata[8*b +: 8];
          touch = 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    localparam int BIDX = (i + 1) / 2;
    localparam int NIB  = (i % 2 == 0) ? 4 : 0;
    assign rd_nx[i] = attr_d[BIDX][NIB];
    assign wr_nx[i] = attr_d[BIDX][NIB+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      attr_q        <= '{default: 8'h00};
      smc_q         <= SMC_INIT;
      shadow_rd_en  <= '0;
      shadow_wr_en  <= '0;
      lowwin_pci_en <= ~SMC_INIT[OPEN_BIT];
      lowwin_smm_en <= SMC_INIT[GEN_BIT];
    end else begin
      attr_q <= attr_d;
      smc_q  <= smc_d;
      if (touch) begin
        shadow_rd_en  <= rd_nx;
        shadow_wr_en  <= wr_nx;
        lowwin_pci_en <= ~smc_d[OPEN_BIT];
        lowwin_smm_en <= smc_d[GEN_BIT];
      end
    end
  end

  function automatic logic [7:0] rd_byte(input logic [CFG_AW-1:0] a);
    logic [7:0] v;
    v = 8'h00;
    if (a == CFG_AW'(SIZE_OFFSET)) v = size_code;
    if (a == CFG_AW'(SMC_OFFSET))  v = smc_q;
    for (int j = 0; j < ATTR_BYTES; j++)
      if (a == CFG_AW'(ATTR_BASE + j)) v = attr_q[j];
    return v;
  endfunction

  always_comb begin
    for (int b = 0; b < 4; b++) cfg_rdata[8*b +: 8] = rd_byte(lane_addr[b]);
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (shadow_rd_en == '0 && shadow_wr_en == '0 &&
                    lowwin_pci_en == ~SMC_INIT[OPEN_BIT] && lowwin_smm_en == SMC_INIT[GEN_BIT]));

  assert_bios_region_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_be[A0_LANE] && cfg_dw_addr == A0_DW) |=>
      (shadow_rd_en[0] == $past(cfg_wdata[A0_LANE*8+4]) &&
       shadow_wr_en[0] == $past(cfg_wdata[A0_LANE*8+5])));

  assert_pci_view_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_be[SMC_LANE] && cfg_dw_addr == SMC_DW) |=>
      (lowwin_pci_en == !$past(cfg_wdata[SMC_LANE*8+OPEN_BIT])));

  assert_smm_view_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_be[SMC_LANE] && cfg_dw_addr == SMC_DW) |=>
      (lowwin_smm_en == $past(cfg_wdata[SMC_LANE*8+GEN_BIT])));

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> ($stable(shadow_rd_en) && $stable(shadow_wr_en) &&
                 $stable(lowwin_pci_en) && $stable(lowwin_smm_en)));
endmodule

// File: tb/hb_memattr_regs_tb.sv
module hb_memattr_regs_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        cfg_we = 0;
  logic [5:0]  cfg_dw_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [15:0] mem_size_mb = 16'd512;
  logic [12:0] shadow_rd_en, shadow_wr_en;
  logic        lowwin_pci_en, lowwin_smm_en;

  int checks = 0;
  int failures = 0;
  logic [7:0] m_attr [7];
  logic [7:0] m_smc;

  always #4 clk = ~clk;

  hb_memattr_regs u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_dw_addr(cfg_dw_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_size_mb(mem_size_mb), .shadow_rd_en(shadow_rd_en),
    .shadow_wr_en(shadow_wr_en), .lowwin_pci_en(lowwin_pci_en),
    .lowwin_smm_en(lowwin_smm_en));

  function automatic logic [7:0] exp_byte(input int a);
    int u;
    if (a >= 'h59 && a <= 'h5F) return m_attr[a - 'h59];
    if (a == 'h72) return m_smc;
    if (a == 'h57) begin
      u = int'(mem_size_mb) / 8;
      return (u > 255) ? 8'hFF : 8'(u);
    end
    return 8'h00;
  endfunction

  function automatic logic [31:0] exp_word(input int dw);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) w[8*k +: 8] = exp_byte(dw*4 + k);
    return w;
  endfunction

  function automatic logic [12:0] exp_rd();
    logic [12:0] v;
    for (int i = 0; i < 13; i++)
      v[i] = (i % 2 == 0) ? m_attr[(i+1)/2][4] : m_attr[(i+1)/2][0];
    return v;
  endfunction

  function automatic logic [12:0] exp_wr();
    logic [12:0] v;
    for (int i = 0; i < 13; i++)
      v[i] = (i % 2 == 0) ? m_attr[(i+1)/2][5] : m_attr[(i+1)/2][1];
    return v;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag);
    check(shadow_rd_en == exp_rd(), {tag, " rd_en"}, 32'(shadow_rd_en), 32'(exp_rd()));
    check(shadow_wr_en == exp_wr(), {tag, " wr_en"}, 32'(shadow_wr_en), 32'(exp_wr()));
    check(lowwin_pci_en == !m_smc[6], {tag, " pci_view"}, 32'(lowwin_pci_en), 32'(!m_smc[6]));
    check(lowwin_smm_en == m_smc[3], {tag, " smm_view"}, 32'(lowwin_smm_en), 32'(m_smc[3]));
  endtask

  task automatic chk_rd(input int dw, input string tag);
    cfg_dw_addr = 6'(dw);
    #1;
    check(cfg_rdata == exp_word(dw), tag, cfg_rdata, exp_word(dw));
  endtask

  task automatic model_wr(input int dw, input logic [3:0] be, input logic [31:0] d);
    for (int k = 0; k < 4; k++) begin
      int a;
      a = dw*4 + k;
      if (be[k]) begin
        if (a >= 'h59 && a <= 'h5F) m_attr[a - 'h59] = d[8*k +: 8];
        if (a == 'h72) m_smc = d[8*k +: 8];
      end
    end
  endtask

  task automatic wr(input int dw, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_dw_addr = 6'(dw); cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0; cfg_be = '0;
    model_wr(dw, be, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int j = 0; j < 7; j++) m_attr[j] = 8'h00;
    m_smc = 8'h02;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    chk_outs("R1 reset");
    chk_rd('h1C, "R1 control byte reset");
    chk_rd('h16, "R1 attr dword 0x58");
    chk_rd('h17, "R1 attr dword 0x5C");

    wr('h16, 4'b0010, 32'h0000_3000);
    chk_outs("R3 bios region");
    check(shadow_rd_en[0] && shadow_wr_en[0], "R3 bios bits", 32'(shadow_rd_en), 32'h1);
    wr('h16, 4'b0010, 32'h0000_2000);
    chk_outs("R3 bios write only");

    for (int j = 0; j < 7; j++) begin
      int a;
      a = 'h59 + j;
      wr(a / 4, 4'(1 << (a % 4)), 32'h0000_0013 << (8 * (a % 4)));
      chk_outs($sformatf("R4 byte %0d low-rd/high-rd", j));
    end
    wr('h17, 4'b1000, 32'h2200_0000);
    chk_outs("R4 regions 11 and 12 write only");
    check(shadow_wr_en[12:11] == 2'b11 && shadow_rd_en[12:11] == 2'b00, "R4 last byte",
          32'({shadow_wr_en[12:11], shadow_rd_en[12:11]}), 32'hC);

    wr('h1C, 4'b0100, 32'h0040_0000);
    chk_outs("R5 open bit set");
    wr('h1C, 4'b0100, 32'h0008_0000);
    chk_outs("R6 global enable set");
    wr('h1C, 4'b0100, 32'h0048_0000);
    chk_outs("R5 R6 both set");
    chk_rd('h1C, "R2 control readback");

    @(negedge clk);
    cfg_we = 1; cfg_dw_addr = 6'h1C; cfg_be = 4'b0100; cfg_wdata = 32'h0000_0000;
    #1;
    chk_outs("R7 before edge");
    @(negedge clk);
    cfg_we = 0; cfg_be = '0;
    model_wr('h1C, 4'b0100, 32'h0);
    chk_outs("R7 after edge");

    wr('h16, 4'b0001, 32'hFFFF_FFFF);
    chk_outs("R7 lane outside range");
    chk_rd('h16, "R9 byte 0x58 ignored");
    wr('h18, 4'b1111, 32'hFFFF_FFFF);
    chk_outs("R7 write beyond range");
    chk_rd('h18, "R9 dword 0x60 zero");
    wr('h1C, 4'b1011, 32'hFFFF_FFFF);
    chk_rd('h1C, "R9 neighbours of 0x72");
    chk_outs("R7 miss control lane");

    mem_size_mb = 16'd40;   chk_rd('h15, "R8 size 40");
    mem_size_mb = 16'd2047; chk_rd('h15, "R8 size 2047");
    mem_size_mb = 16'd2048; chk_rd('h15, "R8 size saturate 2048");
    mem_size_mb = 16'hFFFF; chk_rd('h15, "R8 size max");
    wr('h15, 4'b1000, 32'hAA00_0000);
    chk_rd('h15, "R8 write ignored");
    mem_size_mb = 16'd512;

    for (int n = 0; n < 400; n++) begin
      int dw;
      dw = 'h14 + int'($urandom_range(0, 8));
      wr(dw, 4'($urandom), $urandom);
      chk_outs("R2 R4 R7 random");
      chk_rd('h14 + int'($urandom_range(0, 8)), "R2 R9 random readback");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule